// File: doc/BRIEF.md
# Event Interrupt Aggregator with Port Event Coalescing

This block gathers single-cycle event pulses from ten DMA channels and from the buffer logic of four serial audio outputs and two S/PDIF outputs. Each pulse latches a sticky status bit. Status bits are gated by enable bits of the same layout, and the gated bits are ORed into one registered interrupt line toward the processor.

Software reaches the block through a simple register port: one write strobe, a 3-bit word address, write data and combinational read data. Status words are cleared by writing ones. For the output port events, a coalescing stage can be programmed per group (all serial outputs, S/PDIF output 0, S/PDIF output 1). The stage latches a status bit on every accepted event, on every second one or on every fourth one, which cuts interrupt load when buffers are refilled in bursts. DMA channel events are never coalesced.

Top module: `evt_irq_aggregator`

## Requirements
- R1: Address 0 reads the DMA status, with channel n at bit 2n. A pulse on `dmaDone[n]` sets that bit. At addresses 0 and 1 the odd bits and all bits above bit 19 read 0.
- R2: A write to address 0 or 2 clears each status bit whose data bit is 1. A data bit of 0 leaves its status bit unchanged.
- R3: While a status bit is 1 and is not being cleared in that cycle, events for it are dropped. A dropped port event does not advance its coalescing count.
- R4: The status words read their raw latched value whatever the enables hold. Address 1 holds the DMA enables (channel n at bit 2n) and address 3 holds the port enables. Both are written directly and read back.
- R5: `irq` is a register. In each cycle it equals the OR over all bits of (status AND enable) as they stood one clock earlier.
- R6: Address 2 holds the port status: bits 3:0 serial underflow of ports 0..3, bits 7:4 serial empty, bits 9:8 S/PDIF underflow of outputs 0..1, bits 11:10 S/PDIF empty, and bits 13:12 S/PDIF block complete. Bits above 13 read 0. Address 3 uses the same layout.
- R7: Address 4 holds the coalescing modes: bits 1:0 for the serial group (port status bits 7:0), bits 3:2 for S/PDIF output 0 (bits 8, 10, 12) and bits 5:4 for S/PDIF output 1 (bits 9, 11, 13). Code 0 latches on every accepted event, code 1 on every 2nd and code 2 on every 4th. Reserved code 3 acts as code 0. Every port status bit keeps its own count.
- R8: A write to address 4 resets every coalescing count to zero. Port events in that same cycle are dropped.
- R9: When an event and a clearing write hit the same status bit in one cycle, the event is accepted and the setting wins. For a coalesced bit, the event counts toward its count.
- R10: After reset all status bits, enables, modes and counts are zero, and `irq` is 0.
- R11: DMA channel events latch on every pulse, whatever the coalescing modes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaDone | input | 10 | Completion pulse per DMA channel |
| serUnder | input | 4 | Underflow pulse per serial output |
| serEmpty | input | 4 | Buffer-empty pulse per serial output |
| spdUnder | input | 2 | Underflow pulse per S/PDIF output |
| spdEmpty | input | 2 | Buffer-empty pulse per S/PDIF output |
| spdBlkDone | input | 2 | Block-complete pulse per S/PDIF output |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for `addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the event inputs and the register port hold steady across each rising edge, and that reset is held long enough for every register to load its reset value. The bench changes every input only on the falling clock edge and samples a few nanoseconds after the rising edge, so each pulse lasts exactly one cycle. No event or write is applied while reset is low. The random phase lets events, clears and mode writes coincide freely. These coincidences, including same-cycle set and clear, are legal conditions and not forbidden ones.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DMA_STS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DMA_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PORT_STS = 3'd2;
  localparam logic [ADDR_W-1:0] A_PORT_EN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE     = 3'd4;

  typedef enum logic [1:0] {
    CO_EVERY1 = 2'd0,
    CO_EVERY2 = 2'd1,
    CO_EVERY4 = 2'd2,
    CO_RSVD   = 2'd3
  } coalMode_e;

  // strobes from control decode into the datapath
  typedef struct packed {
    logic dmaClrWr;
    logic dmaEnWr;
    logic portClrWr;
    logic portEnWr;
    logic modeWr;
  } regStrb_t;

  // last count value before a latch for a given mode; reserved acts as every-1
  function automatic logic [1:0] coalLimit(input logic [1:0] mode);
    case (coalMode_e'(mode))
      CO_EVERY2: return 2'd1;
      CO_EVERY4: return 2'd3;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrb_t          strb
);

  always_comb begin
    strb           = '0;
    strb.dmaClrWr  = wrEn && (addr == A_DMA_STS);
    strb.dmaEnWr   = wrEn && (addr == A_DMA_EN);
    strb.portClrWr = wrEn && (addr == A_PORT_STS);
    strb.portEnWr  = wrEn && (addr == A_PORT_EN);
    strb.modeWr    = wrEn && (addr == A_MODE);
  end

endmodule

// File: rtl/evt_irq_coalescer.sv
module evt_irq_coalescer
  import evt_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evt,
  input  logic       stsBit,
  input  logic       clrBit,
  input  logic       modeWr,
  input  logic [1:0] mode,
  output logic       setOut
);

  logic [1:0] cnt;
  logic [1:0] limit;
  logic       accept;

  assign limit  = coalLimit(mode);
  // lockout unless the bit is being cleared this cycle; mode write drops events
  assign accept = evt && (!stsBit || clrBit) && !modeWr;
  assign setOut = accept && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (modeWr) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= (cnt == limit) ? 2'd0 : cnt + 2'd1;
    end
  end

endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
#(
  parameter int NUM_DMA = 10,
  parameter int NUM_SER = 4,
  parameter int NUM_SPD = 2,
  parameter int DATA_W  = 32,
  localparam int PORT_W = 2*NUM_SER + 3*NUM_SPD,
  localparam int MODE_W = 2*(1 + NUM_SPD)
)(
  input  logic               clk,
  input  logic               rstN,
  input  regStrb_t           strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_DMA-1:0] dmaEvt,
  input  logic [PORT_W-1:0]  portEvt,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_DMA-1:0] dmaSts,
  output logic [NUM_DMA-1:0] dmaEn,
  output logic [PORT_W-1:0]  portSts,
  output logic [PORT_W-1:0]  portEn,
  output logic               irq
);

  logic [NUM_DMA-1:0] dmaClr;
  logic [NUM_DMA-1:0] dmaSet;
  logic [NUM_DMA-1:0] dmaEnVal;
  logic [PORT_W-1:0]  portClr;
  logic [PORT_W-1:0]  portSet;
  logic [MODE_W-1:0]  modeReg;
  logic [DATA_W-1:0]  dmaStsRd;
  logic [DATA_W-1:0]  dmaEnRd;
  logic               unusedWr;

  assign unusedWr = ^wrData;

  // DMA channel n lives at even bit 2n of its words
  genvar n;
  for (n = 0; n < NUM_DMA; n++) begin : g_dma
    assign dmaClr[n]       = strb.dmaClrWr && wrData[2*n];
    assign dmaEnVal[n]     = wrData[2*n];
    assign dmaStsRd[2*n]   = dmaSts[n];
    assign dmaStsRd[2*n+1] = 1'b0;
    assign dmaEnRd[2*n]    = dmaEn[n];
    assign dmaEnRd[2*n+1]  = 1'b0;
  end
  if (DATA_W > 2*NUM_DMA) begin : g_dma_pad
    assign dmaStsRd[DATA_W-1:2*NUM_DMA] = '0;
    assign dmaEnRd[DATA_W-1:2*NUM_DMA]  = '0;
  end

  assign dmaSet  = dmaEvt & (~dmaSts | dmaClr);
  assign portClr = strb.portClrWr ? wrData[PORT_W-1:0] : '0;

  // one coalescer per port status bit, mode taken from the bit's group
  genvar b;
  for (b = 0; b < PORT_W; b++) begin : g_port
    localparam int GRP = (b < 2*NUM_SER) ? 0 : 1 + ((b - 2*NUM_SER) % NUM_SPD);
    evt_irq_coalescer u_coal (
      .clk    (clk),
      .rstN   (rstN),
      .evt    (portEvt[b]),
      .stsBit (portSts[b]),
      .clrBit (portClr[b]),
      .modeWr (strb.modeWr),
      .mode   (modeReg[2*GRP +: 2]),
      .setOut (portSet[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaSts  <= '0;
      dmaEn   <= '0;
      portSts <= '0;
      portEn  <= '0;
      modeReg <= '0;
      irq     <= 1'b0;
    end else begin
      dmaSts  <= dmaSet | (dmaSts & ~dmaClr);
      portSts <= portSet | (portSts & ~portClr);
      if (strb.dmaEnWr)  dmaEn   <= dmaEnVal;
      if (strb.portEnWr) portEn  <= wrData[PORT_W-1:0];
      if (strb.modeWr)   modeReg <= wrData[MODE_W-1:0];
      irq <= (|(dmaSts & dmaEn)) || (|(portSts & portEn));
    end
  end

  always_comb begin
    case (addr)
      A_DMA_STS:  rdData = dmaStsRd;
      A_DMA_EN:   rdData = dmaEnRd;
      A_PORT_STS: rdData = {{(DATA_W-PORT_W){1'b0}}, portSts};
      A_PORT_EN:  rdData = {{(DATA_W-PORT_W){1'b0}}, portEn};
      A_MODE:     rdData = {{(DATA_W-MODE_W){1'b0}}, modeReg};
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_irq_pkg::*;
#(
  parameter int NUM_DMA = 10,
  parameter int NUM_SER = 4,
  parameter int NUM_SPD = 2,
  parameter int DATA_W  = 32,
  localparam int PORT_W = 2*NUM_SER + 3*NUM_SPD
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DMA-1:0] dmaDone,
  input  logic [NUM_SER-1:0] serUnder,
  input  logic [NUM_SER-1:0] serEmpty,
  input  logic [NUM_SPD-1:0] spdUnder,
  input  logic [NUM_SPD-1:0] spdEmpty,
  input  logic [NUM_SPD-1:0] spdBlkDone,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  regStrb_t           strb;
  logic [PORT_W-1:0]  portEvt;
  logic [NUM_DMA-1:0] dmaSts;
  logic [NUM_DMA-1:0] dmaEn;
  logic [PORT_W-1:0]  portSts;
  logic [PORT_W-1:0]  portEn;

  assign portEvt = {spdBlkDone, spdEmpty, spdUnder, serEmpty, serUnder};

  evt_irq_ctrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  evt_irq_datapath #(
    .NUM_DMA (NUM_DMA),
    .NUM_SER (NUM_SER),
    .NUM_SPD (NUM_SPD),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .wrData  (wrData),
    .dmaEvt  (dmaDone),
    .portEvt (portEvt),
    .rdData  (rdData),
    .dmaSts  (dmaSts),
    .dmaEn   (dmaEn),
    .portSts (portSts),
    .portEn  (portEn),
    .irq     (irq)
  );

endmodule

// File: rtl/evt_irq_checks.sv
module evt_irq_checks
  import evt_irq_pkg::*;
#(
  parameter int NUM_DMA = 10,
  parameter int PORT_W  = 14,
  parameter int DATA_W  = 32
)(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [NUM_DMA-1:0] dmaEvt,
  input logic [PORT_W-1:0]  portEvt,
  input logic [NUM_DMA-1:0] dmaSts,
  input logic [NUM_DMA-1:0] dmaEn,
  input logic [PORT_W-1:0]  portSts,
  input logic [PORT_W-1:0]  portEn,
  input logic [DATA_W-1:0]  rdData,
  input logic               irq
);

  function automatic logic [DATA_W-1:0] unusedMask();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i % 2 == 1) || (i >= 2*NUM_DMA);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] DMA_ZERO_MASK = unusedMask();

  logic [NUM_DMA-1:0] dmaClrM;
  logic [PORT_W-1:0]  portClrM;
  logic               gated;

  for (genvar n = 0; n < NUM_DMA; n++) begin : g_clr
    assign dmaClrM[n] = wrEn && (addr == A_DMA_STS) && wrData[2*n];
  end
  assign portClrM = (wrEn && (addr == A_PORT_STS)) ? wrData[PORT_W-1:0] : '0;
  assign gated    = (|(dmaSts & dmaEn)) || (|(portSts & portEn));

  // R5: registered interrupt follows gated status one clock later
  p_irq_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (irq == $past(gated)));

  // R3: a set DMA bit only falls when a clearing write hits it
  p_dma_lockout_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((($past(dmaSts) & ~$past(dmaClrM)) & ~dmaSts) == '0));

  // R2: a set port bit only falls when a clearing write hits it
  p_port_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((($past(portSts) & ~$past(portClrM)) & ~portSts) == '0));

  // R1: DMA status rises only after its event pulse
  p_dma_set_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((dmaSts & ~$past(dmaSts) & ~$past(dmaEvt)) == '0));

  // R6: port status rises only after its event pulse
  p_port_set_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((portSts & ~$past(portSts) & ~$past(portEvt)) == '0));

  // R1: unused bits of the DMA words read zero
  p_dma_zero_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_DMA_STS || addr == A_DMA_EN) |-> ((rdData & DMA_ZERO_MASK) == '0));

  // R4: enables only change on their own write
  p_en_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == A_DMA_EN) |=> $stable(dmaEn));

  // R8: no port bit rises in the cycle a mode write lands
  p_mode_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_MODE) |=> ((portSts & ~$past(portSts)) == '0));

endmodule

bind evt_irq_aggregator evt_irq_checks #(
  .NUM_DMA (NUM_DMA),
  .PORT_W  (PORT_W),
  .DATA_W  (DATA_W)
) u_checks (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .dmaEvt  (dmaDone),
  .portEvt (portEvt),
  .dmaSts  (dmaSts),
  .dmaEn   (dmaEn),
  .portSts (portSts),
  .portEn  (portEn),
  .rdData  (rdData),
  .irq     (irq)
);

// File: tb/evt_irq_aggregator_test.sv
module evt_irq_aggregator_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  dmaDone = '0;
  logic [13:0] pv = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int    total = 0;
  int    bad = 0;
  bit    started = 0;
  string curReq = "R10";

  always #4 clk = ~clk;

  evt_irq_aggregator uut (
    .clk        (clk),
    .rstN       (rstN),
    .dmaDone    (dmaDone),
    .serUnder   (pv[3:0]),
    .serEmpty   (pv[7:4]),
    .spdUnder   (pv[9:8]),
    .spdEmpty   (pv[11:10]),
    .spdBlkDone (pv[13:12]),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .irq        (irq)
  );

  // ---------------- behavioural reference ----------------
  bit [9:0]  mDma, mDmaEn;
  bit [13:0] mPort, mPortEn;
  bit [5:0]  mMode;
  int        mCnt [14];
  bit        mIrq;

  function automatic int every(int code);
    if (code == 1) return 2;
    if (code == 2) return 4;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDma = 0; mDmaEn = 0; mPort = 0; mPortEn = 0; mMode = 0; mIrq = 0;
      foreach (mCnt[i]) mCnt[i] = 0;
    end else begin
      bit nIrq;
      bit modeW;
      nIrq  = ((mDma & mDmaEn) != 0) || ((mPort & mPortEn) != 0);
      modeW = wrEn && addr == 4;
      for (int n = 0; n < 10; n++) begin
        bit clr;
        clr = wrEn && addr == 0 && wrData[2*n];
        if (dmaDone[n] && (!mDma[n] || clr)) mDma[n] = 1;
        else if (clr) mDma[n] = 0;
      end
      for (int b = 0; b < 14; b++) begin
        bit clr;
        bit setIt;
        int g;
        int lim;
        clr   = wrEn && addr == 2 && wrData[b];
        setIt = 0;
        g     = (b < 8) ? 0 : 1 + ((b - 8) % 2);
        lim   = every((mMode >> (2*g)) & 3);
        if (modeW) mCnt[b] = 0;
        else if (pv[b] && (!mPort[b] || clr)) begin
          mCnt[b]++;
          if (mCnt[b] >= lim) begin setIt = 1; mCnt[b] = 0; end
        end
        if (setIt) mPort[b] = 1;
        else if (clr) mPort[b] = 0;
      end
      if (wrEn && addr == 1) for (int n = 0; n < 10; n++) mDmaEn[n] = wrData[2*n];
      if (wrEn && addr == 3) mPortEn = wrData[13:0];
      if (modeW) mMode = wrData[5:0];
      mIrq = nIrq;
    end
  end

  function automatic logic [31:0] expRd(logic [2:0] a);
    logic [31:0] r;
    r = 0;
    case (a)
      3'd0: for (int n = 0; n < 10; n++) r[2*n] = mDma[n];
      3'd1: for (int n = 0; n < 10; n++) r[2*n] = mDmaEn[n];
      3'd2: r[13:0] = mPort;
      3'd3: r[13:0] = mPortEn;
      3'd4: r[5:0] = mMode;
      default: r = 0;
    endcase
    return r;
  endfunction

  // compare a few ns after every rising edge, well before the inputs move
  always @(posedge clk) begin
    #3;
    if (started) begin
      total++;
      if (rdData !== expRd(addr)) begin
        bad++;
        $display("FAIL %s rdData addr=%0d actual=%h expected=%h", curReq, addr, rdData, expRd(addr));
      end
      total++;
      if (irq !== mIrq) begin
        bad++;
        $display("FAIL %s irq actual=%b expected=%b", curReq, irq, mIrq);
      end
    end
  end

  // one cycle of stimulus, applied on the falling edge
  task automatic cyc(bit w, logic [2:0] a, logic [31:0] d, logic [9:0] dma, logic [13:0] p);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; dmaDone = dma; pv = p;
  endtask

  task automatic rd(logic [2:0] a);
    cyc(0, a, 0, 0, 0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cyc(1, a, d, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    started = 1;
    curReq = "R10";
    for (int a = 0; a < 8; a++) rd(a[2:0]);

    curReq = "R1";
    cyc(0, 0, 0, 10'h201, 0);
    rd(0); rd(1);
    cyc(0, 0, 0, 10'h0F0, 0);
    rd(0);

    curReq = "R4";
    rd(0); rd(2);

    curReq = "R5";
    wr(1, 32'h0000_0001);
    rd(0); rd(0);
    wr(1, 32'h0000_0002);
    rd(1); rd(1);
    wr(1, 32'h000A_AAAA);
    rd(1); rd(1);

    curReq = "R2";
    wr(0, 32'h0000_0001);
    rd(0);
    wr(0, 32'h0000_0000);
    rd(0);
    wr(0, 32'hFFFF_FFFF);
    rd(0); rd(0);

    curReq = "R3";
    cyc(0, 0, 0, 10'h004, 0);
    cyc(0, 0, 0, 10'h004, 0);
    wr(0, 32'h0000_0010);
    rd(0);

    curReq = "R9";
    cyc(0, 0, 0, 10'h008, 0);
    cyc(1, 0, 32'h0000_0040, 10'h008, 0);
    rd(0);

    curReq = "R6";
    cyc(0, 2, 0, 0, 14'h2A55);
    rd(2);
    wr(3, 32'h0000_3FFF);
    rd(3); rd(3);
    wr(2, 32'h0000_3FFF);
    rd(2);
    wr(3, 0);

    curReq = "R7";
    wr(4, 32'h0000_0021);
    rd(4);
    for (int k = 0; k < 5; k++) begin
      cyc(0, 2, 0, 0, 14'h1201);
      rd(2);
    end
    wr(2, 32'h0000_3FFF);
    wr(4, 32'h0000_003F);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 2, 0, 0, 14'h0A30);
      wr(2, 32'h0000_3FFF);
    end

    curReq = "R8";
    wr(4, 32'h0000_002A);
    cyc(0, 2, 0, 0, 14'h0101);
    cyc(0, 2, 0, 0, 14'h0101);
    cyc(1, 4, 32'h0000_002A, 0, 14'h0101);
    cyc(0, 2, 0, 0, 14'h0101);
    cyc(0, 2, 0, 0, 14'h0101);
    cyc(0, 2, 0, 0, 14'h0101);
    rd(2);
    cyc(0, 2, 0, 0, 14'h0101);
    rd(2);

    curReq = "R9";
    wr(4, 32'h0000_0001);
    cyc(0, 2, 0, 0, 14'h0002);
    cyc(0, 2, 0, 0, 14'h0002);
    cyc(1, 2, 32'h0000_0002, 0, 14'h0002);
    cyc(1, 2, 32'h0000_0002, 0, 14'h0002);
    rd(2);

    curReq = "R11";
    wr(4, 32'h0000_002A);
    wr(0, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 10'h3FF, 0);
    rd(0);

    curReq = "R2 R3 R5 R7 R9 random";
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] a;
      logic [31:0] d;
      logic [9:0] dm;
      logic [13:0] p;
      a  = 3'($urandom_range(0, 5));
      d  = $urandom;
      dm = 10'($urandom) & 10'($urandom);
      p  = 14'($urandom) & 14'($urandom);
      cyc(($urandom_range(0, 3) == 0), a, d, dm, p);
    end
    rd(0);
    rd(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    total++;
    bad++;
    $display("FAIL watchdog expired in %s actual=running expected=finished", curReq);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule